// File: doc/BRIEF.md
# Curve-to-LUT Interpolator

This engine turns a short list of control points into a complete gamma table. Each control point holds three 16-bit colour components. After a one-cycle `start`, the engine walks the curve one segment at a time. For every output position covered by a segment it blends the segment's two end points linearly and keeps the top `CW` bits of each blended component. It packs the three results into a single word and offers that word, together with its table position, on a valid/ready write port. That port can feed the load side of a lookup memory directly.

The engine reads the control points through a combinational read port: it drives `pt_addr` and samples `pt_r`/`pt_g`/`pt_b` in the same cycle. The point count is taken from `num_pts` at start. A count below two selects a built-in straight ramp from all-zero to full scale. The table length `N_ENTRIES` (256 or 1024 in practice) and the component width `CW` are parameters. Every division is done exactly by a restoring divider, so results match truncating integer arithmetic bit for bit.

Top module: `curve_lut`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `wr_valid` and `done` are 0.
- R2: With L effective points, segment i (i = 0 .. L-2, in ascending order) covers table positions from s = i*(N_ENTRIES-1)/(L-1) to e = (i+1)*(N_ENTRIES-1)/(L-1), with truncating division. Its writes carry `wr_idx` = s, s+1, ..., e in that order, and the first write of a run has `wr_idx` 0.
- R3: A segment with e == s produces no write at all.
- R4: With width w = e - s, the write at offset k (0..w) of segment i carries, per component, (P[i]*(w-k) + P[i+1]*k) / w with truncating division, where P[i] is the point read from address i.
- R5: Each blended 16-bit component is shifted right by 16-CW. `wr_data` holds red in bits [3CW-1:2CW], green in [2CW-1:CW] and blue in [CW-1:0].
- R6: Position e of a segment is written once more as position s of the next non-empty segment, carrying the later segment's value. Consecutive accepted indices therefore differ by 0 or +1.
- R7: When `num_pts` is 0 or 1, the engine ignores the point port and uses two points: (0,0,0) and (65535,65535,65535).
- R8: A `num_pts` above `MAX_PTS` is treated as `MAX_PTS`.
- R9: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_idx` and `wr_data` hold their values into the next cycle.
- R10: `done` is a one-cycle pulse in the cycle right after the final write is accepted. `wr_valid` is low while `done` is high.
- R11: `start` and `num_pts` are sampled only while idle. A `start` pulse, or a change of `num_pts`, during a run leaves that run's writes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a table build when idle |
| num_pts | input | $clog2(MAX_PTS+1) | Number of control points |
| pt_addr | output | $clog2(MAX_PTS) | Control point read address |
| pt_r | input | 16 | Red component at `pt_addr` (same cycle) |
| pt_g | input | 16 | Green component at `pt_addr` |
| pt_b | input | 16 | Blue component at `pt_addr` |
| wr_valid | output | 1 | Table write offered |
| wr_ready | input | 1 | Table write accepted on this edge |
| wr_idx | output | $clog2(N_ENTRIES) | Table position of the write |
| wr_data | output | 3*CW | Packed table entry |
| done | output | 1 | Build finished pulse |

## Verification
Each write appears NW+3 cycles after the previous one is accepted, where NW = 16 + max($clog2(N_ENTRIES), $clog2(MAX_PTS+1)) is the divider length. Each segment boundary adds about NW+4 cycles before its first write. `done` rises in the cycle right after the last accepted handshake. The bench does not predict the cycle of each write. It drives `wr_ready` at each falling edge, then records a handshake whenever valid and ready are both high before the next rising edge. It compares the recorded sequence with a model of the whole curve and checks that `done` arrives exactly one sampled cycle after the last recorded handshake.

// File: rtl/curve_lut_pkg.sv
package curve_lut_pkg;

    localparam int SrcW = 16;
    localparam logic [SrcW-1:0] FullScale = '1;

    typedef struct packed {
        logic [SrcW-1:0] r;
        logic [SrcW-1:0] g;
        logic [SrcW-1:0] b;
    } rgb16_t;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_BOUND,
        ST_BWAIT,
        ST_FETCH_A,
        ST_FETCH_B,
        ST_ISSUE,
        ST_IWAIT,
        ST_EMIT,
        ST_FIN
    } eng_state_t;

    function automatic logic [SrcW-1:0] pick(input rgb16_t p, input int k);
        case (k)
            0:       return p.r;
            1:       return p.g;
            default: return p.b;
        endcase
    endfunction

endpackage

// File: rtl/curve_div.sv
module curve_div #(
    parameter int NW   = 26,
    parameter int DW   = 10,
    parameter int OW   = 10,
    parameter int OLSB = 0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          go,
    input  logic [NW-1:0] num,
    input  logic [DW-1:0] den,
    output logic          busy,
    output logic [OW-1:0] quo
);
    localparam int CNTW = $clog2(NW + 1);

    logic [NW-1:0]   q_q;
    logic [DW-1:0]   rem_q;
    logic [DW-1:0]   den_q;
    logic [CNTW-1:0] cnt_q;
    logic [DW:0]     trial;
    logic            fits;

    always_comb begin
        trial = {rem_q, q_q[NW-1]};
        fits  = trial >= {1'b0, den_q};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q_q   <= '0;
            rem_q <= '0;
            den_q <= '0;
            cnt_q <= '0;
            busy  <= 1'b0;
        end else if (go && !busy) begin
            q_q   <= num;
            rem_q <= '0;
            den_q <= den;
            cnt_q <= CNTW'(NW);
            busy  <= 1'b1;
        end else if (busy) begin
            q_q   <= {q_q[NW-2:0], fits};
            rem_q <= fits ? DW'(trial - {1'b0, den_q}) : trial[DW-1:0];
            cnt_q <= cnt_q - CNTW'(1);
            if (cnt_q == CNTW'(1)) begin
                busy <= 1'b0;
            end
        end
    end

    assign quo = q_q[OLSB +: OW];

endmodule

// File: rtl/curve_lane.sv
module curve_lane
    import curve_lut_pkg::*;
#(
    parameter int CW = 8,
    parameter int DW = 10,
    parameter int NW = 26
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            go,
    input  logic [SrcW-1:0] a,
    input  logic [SrcW-1:0] b,
    input  logic [DW-1:0]   w,
    input  logic [DW-1:0]   j,
    output logic            busy,
    output logic [CW-1:0]   comp
);
    logic [NW-1:0] num;

    // weighted sum of the two end points; never exceeds 65535*w
    always_comb begin
        num = NW'(a) * NW'(w - j) + NW'(b) * NW'(j);
    end

    // quotient fits 16 bits; keep only its top CW bits
    curve_div #(
        .NW  (NW),
        .DW  (DW),
        .OW  (CW),
        .OLSB(SrcW - CW)
    ) u_div (
        .clk (clk),
        .rst (rst),
        .go  (go),
        .num (num),
        .den (w),
        .busy(busy),
        .quo (comp)
    );

endmodule

// File: rtl/curve_lut.sv
module curve_lut
    import curve_lut_pkg::*;
#(
    parameter int N_ENTRIES = 256,
    parameter int CW        = 8,
    parameter int MAX_PTS   = 512
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         start,
    input  logic [$clog2(MAX_PTS+1)-1:0] num_pts,
    output logic [$clog2(MAX_PTS)-1:0]   pt_addr,
    input  logic [15:0]                  pt_r,
    input  logic [15:0]                  pt_g,
    input  logic [15:0]                  pt_b,
    output logic                         wr_valid,
    input  logic                         wr_ready,
    output logic [$clog2(N_ENTRIES)-1:0] wr_idx,
    output logic [3*CW-1:0]              wr_data,
    output logic                         done
);
    localparam int IDXW = $clog2(N_ENTRIES);
    localparam int PAW  = $clog2(MAX_PTS);
    localparam int PTW  = $clog2(MAX_PTS + 1);
    localparam int DW   = (IDXW > PTW) ? IDXW : PTW;
    localparam int NW   = SrcW + DW;
    localparam int PW   = 3 * CW;

    eng_state_t     st_q;
    logic [PTW-1:0] npts_q;
    logic [PTW-1:0] seg_q;
    logic           dflt_q;
    logic [DW-1:0]  first_q;
    logic [DW-1:0]  last_q;
    logic [DW-1:0]  j_q;
    rgb16_t         pa_q;
    rgb16_t         pb_q;
    logic [PW-1:0]  out_q;

    rgb16_t         fetched;
    logic [DW-1:0]  width;
    logic           last_seg;
    logic           bdiv_busy;
    logic [DW-1:0]  bquo;
    logic [NW-1:0]  bnum;
    logic [2:0]     lane_busy;
    logic [CW-1:0]  comp [3];

    assign width    = last_q - first_q;
    assign last_seg = (seg_q + PTW'(2)) == npts_q;
    assign bnum     = (NW'(seg_q) + NW'(1)) * NW'(N_ENTRIES - 1);
    assign pt_addr  = (st_q == ST_FETCH_B) ? PAW'(seg_q + PTW'(1)) : PAW'(seg_q);

    always_comb begin
        if (dflt_q) begin
            fetched = (st_q == ST_FETCH_B) ? {3{FullScale}} : '0;
        end else begin
            fetched = '{r: pt_r, g: pt_g, b: pt_b};
        end
    end

    // segment end position: (seg+1)*(N-1)/(L-1)
    curve_div #(
        .NW  (NW),
        .DW  (DW),
        .OW  (DW),
        .OLSB(0)
    ) u_bound (
        .clk (clk),
        .rst (rst),
        .go  (st_q == ST_BOUND),
        .num (bnum),
        .den (DW'(npts_q - PTW'(1))),
        .busy(bdiv_busy),
        .quo (bquo)
    );

    // one interpolation lane per colour component, red first
    for (genvar k = 0; k < 3; k++) begin : g_lane
        curve_lane #(
            .CW(CW),
            .DW(DW),
            .NW(NW)
        ) u_lane (
            .clk (clk),
            .rst (rst),
            .go  (st_q == ST_ISSUE),
            .a   (pick(pa_q, k)),
            .b   (pick(pb_q, k)),
            .w   (width),
            .j   (j_q),
            .busy(lane_busy[k]),
            .comp(comp[k])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            npts_q  <= PTW'(2);
            seg_q   <= '0;
            dflt_q  <= 1'b0;
            first_q <= '0;
            last_q  <= '0;
            j_q     <= '0;
            pa_q    <= '0;
            pb_q    <= '0;
            out_q   <= '0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (start) begin
                        seg_q   <= '0;
                        first_q <= '0;
                        dflt_q  <= num_pts < PTW'(2);
                        if (num_pts < PTW'(2)) begin
                            npts_q <= PTW'(2);
                        end else if (num_pts > PTW'(MAX_PTS)) begin
                            npts_q <= PTW'(MAX_PTS);
                        end else begin
                            npts_q <= num_pts;
                        end
                        st_q <= ST_BOUND;
                    end
                end
                ST_BOUND: st_q <= ST_BWAIT;
                ST_BWAIT: begin
                    if (!bdiv_busy) begin
                        last_q <= bquo;
                        if (bquo == first_q) begin
                            if (last_seg) begin
                                st_q <= ST_FIN;
                            end else begin
                                seg_q <= seg_q + PTW'(1);
                                st_q  <= ST_BOUND;
                            end
                        end else begin
                            st_q <= ST_FETCH_A;
                        end
                    end
                end
                ST_FETCH_A: begin
                    pa_q <= fetched;
                    st_q <= ST_FETCH_B;
                end
                ST_FETCH_B: begin
                    pb_q <= fetched;
                    j_q  <= '0;
                    st_q <= ST_ISSUE;
                end
                ST_ISSUE: st_q <= ST_IWAIT;
                ST_IWAIT: begin
                    if (lane_busy == 3'b000) begin
                        out_q <= {comp[0], comp[1], comp[2]};
                        st_q  <= ST_EMIT;
                    end
                end
                ST_EMIT: begin
                    if (wr_ready) begin
                        if (j_q == width) begin
                            first_q <= last_q;
                            if (last_seg) begin
                                st_q <= ST_FIN;
                            end else begin
                                seg_q <= seg_q + PTW'(1);
                                st_q  <= ST_BOUND;
                            end
                        end else begin
                            j_q  <= j_q + DW'(1);
                            st_q <= ST_ISSUE;
                        end
                    end
                end
                ST_FIN:  st_q <= ST_IDLE;
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign wr_valid = (st_q == ST_EMIT);
    assign wr_idx   = IDXW'(first_q + j_q);
    assign wr_data  = out_q;
    assign done     = (st_q == ST_FIN);

endmodule

// File: rtl/curve_lut_chk.sv
module curve_lut_chk #(
    parameter int N_ENTRIES = 256,
    parameter int CW        = 8
) (
    input logic                         clk,
    input logic                         rst,
    input logic                         wr_valid,
    input logic                         wr_ready,
    input logic [$clog2(N_ENTRIES)-1:0] wr_idx,
    input logic [3*CW-1:0]              wr_data,
    input logic                         done
);
    localparam int IDXW = $clog2(N_ENTRIES);

    logic [IDXW-1:0] prev_q;
    logic            have_q;

    always_ff @(posedge clk) begin
        if (rst || done) begin
            have_q <= 1'b0;
            prev_q <= '0;
        end else if (wr_valid && wr_ready) begin
            have_q <= 1'b1;
            prev_q <= wr_idx;
        end
    end

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!wr_valid && !done));

    assert_first_idx_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_ready && !have_q) |-> (wr_idx == '0));

    assert_idx_step_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_ready && have_q) |->
            (wr_idx == prev_q || wr_idx == IDXW'(prev_q + 1'b1)));

    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_idx) && $stable(wr_data)));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        done |-> !wr_valid);

endmodule

bind curve_lut curve_lut_chk #(
    .N_ENTRIES(N_ENTRIES),
    .CW       (CW)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_valid(wr_valid),
    .wr_ready(wr_ready),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .done    (done)
);

// File: tb/curve_lut_tb.sv
module curve_lut_tb;
    import curve_lut_pkg::*;

    localparam int N     = 256;
    localparam int CW    = 8;
    localparam int MAXP  = 512;
    localparam int PTW   = $clog2(MAXP + 1);
    localparam int PAW   = $clog2(MAXP);
    localparam int IDXW  = $clog2(N);
    localparam int PW    = 3 * CW;
    localparam int CAP   = 4096;
    localparam int LIMIT = 190000;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            start = 1'b0;
    logic [PTW-1:0]  num_pts = '0;
    logic [PAW-1:0]  pt_addr;
    logic [15:0]     pt_r, pt_g, pt_b;
    logic            wr_valid;
    logic            wr_ready = 1'b0;
    logic [IDXW-1:0] wr_idx;
    logic [PW-1:0]   wr_data;
    logic            done;

    always #5 clk = ~clk;

    rgb16_t mem [MAXP];
    assign pt_r = mem[pt_addr].r;
    assign pt_g = mem[pt_addr].g;
    assign pt_b = mem[pt_addr].b;

    curve_lut #(.N_ENTRIES(N), .CW(CW), .MAX_PTS(MAXP)) u_dut (
        .clk(clk), .rst(rst), .start(start), .num_pts(num_pts),
        .pt_addr(pt_addr), .pt_r(pt_r), .pt_g(pt_g), .pt_b(pt_b),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_idx(wr_idx),
        .wr_data(wr_data), .done(done)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit wd_hit = 1'b0;

    int            act_n, exp_n;
    logic [IDXW-1:0] act_idx [CAP];
    logic [PW-1:0]   act_dat [CAP];
    logic [IDXW-1:0] exp_idx [CAP];
    logic [PW-1:0]   exp_dat [CAP];

    int stp, hs_stp, done_stp;
    bit pv_valid, pv_ready;
    logic [IDXW-1:0] pv_idx;
    logic [PW-1:0]   pv_dat;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic longint ptval(input int npts, input int idx, input int c);
        if (npts < 2) return (idx == 0) ? 0 : 65535;
        return (c == 0) ? longint'(mem[idx].r) : (c == 1) ? longint'(mem[idx].g) : longint'(mem[idx].b);
    endfunction

    // expected write sequence computed from the segment arithmetic
    task automatic model(input int npts);
        int L;
        L = (npts < 2) ? 2 : ((npts > MAXP) ? MAXP : npts);
        exp_n = 0;
        for (int i = 0; i < L - 1; i++) begin
            longint s, e, w;
            s = longint'(i) * (N - 1) / (L - 1);
            e = longint'(i + 1) * (N - 1) / (L - 1);
            w = e - s;
            if (w == 0) continue;
            for (longint k = 0; k <= w; k++) begin
                logic [PW-1:0] word;
                word = '0;
                for (int c = 0; c < 3; c++) begin
                    longint v;
                    v = (ptval(npts, i, c) * (w - k) + ptval(npts, i + 1, c) * k) / w;
                    v = v >> (16 - CW);
                    word = (word << CW) | PW'(v);
                end
                if (exp_n < CAP) begin
                    exp_idx[exp_n] = IDXW'(s + k);
                    exp_dat[exp_n] = word;
                end
                exp_n++;
            end
        end
    endtask

    task automatic step(input int rdy_pct);
        @(negedge clk);
        stp++;
        cyc++;
        if (cyc > LIMIT) wd_hit = 1'b1;
        if (pv_valid && !pv_ready) begin
            check(wr_valid && wr_idx == pv_idx && wr_data == pv_dat, "R9",
                  "stalled write changed", longint'(wr_data), longint'(pv_dat));
        end
        if (done) done_stp = stp;
        wr_ready = (int'($urandom % 100) < rdy_pct);
        #1;
        pv_valid = wr_valid;
        pv_ready = wr_ready;
        pv_idx   = wr_idx;
        pv_dat   = wr_data;
        if (wr_valid && wr_ready) begin
            if (act_n < CAP) begin
                act_idx[act_n] = wr_idx;
                act_dat[act_n] = wr_data;
            end
            act_n++;
            hs_stp = stp;
        end
    endtask

    task automatic run_curve(input string tag, input int npts, input int rdy_pct, input bit poke);
        if (wd_hit) return;
        model(npts);
        act_n = 0; stp = 0; hs_stp = -1; done_stp = -1;
        pv_valid = 1'b0; pv_ready = 1'b0;
        num_pts = PTW'(npts);
        start = 1'b1;
        step(rdy_pct);
        start = 1'b0;
        while (done_stp < 0 && !wd_hit) begin
            if (poke && stp == 60) begin
                // R11: mid-run start with a different count must be ignored
                num_pts = PTW'(3);
                start = 1'b1;
                step(rdy_pct);
                start = 1'b0;
            end else begin
                step(rdy_pct);
            end
        end
        wr_ready = 1'b0;
        if (wd_hit) begin
            check(1'b0, tag, "watchdog expired", cyc, LIMIT);
            return;
        end
        check(act_n == exp_n, tag, "write count", act_n, exp_n);
        for (int i = 0; i < exp_n && i < act_n && i < CAP; i++) begin
            check(act_idx[i] == exp_idx[i], "R2 R6", "write index", longint'(act_idx[i]), longint'(exp_idx[i]));
            check(act_dat[i] == exp_dat[i], tag, "entry data (R4 R5)", longint'(act_dat[i]), longint'(exp_dat[i]));
        end
        check(done_stp == hs_stp + 1, "R10", "done cycle after last write", done_stp, hs_stp + 1);
        step(100);
        check(!done && !wr_valid, "R10", "idle after done", longint'({done, wr_valid}), 0);
    endtask

    task automatic fill_random();
        for (int i = 0; i < MAXP; i++) begin
            mem[i].r = 16'($urandom);
            mem[i].g = 16'($urandom);
            mem[i].b = 16'($urandom);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        fill_random();
        repeat (3) @(negedge clk);
        check(!wr_valid && !done, "R1", "outputs during reset", longint'({wr_valid, done}), 0);
        rst = 1'b0;
        @(negedge clk);
        check(!wr_valid && !done, "R1", "outputs after reset", longint'({wr_valid, done}), 0);

        run_curve("R7", 0, 100, 1'b0);
        run_curve("R7", 1, 70, 1'b0);
        run_curve("R4", 2, 100, 1'b0);
        run_curve("R4", 5, 60, 1'b0);
        run_curve("R9", 16, 40, 1'b0);

        // directed extremes to pin component positions
        for (int i = 0; i < 12; i++) begin
            mem[i].r = (i % 2 == 0) ? 16'hFFFF : 16'h0000;
            mem[i].g = (i % 2 == 0) ? 16'h0000 : 16'hFFFF;
            mem[i].b = (i % 3 == 0) ? 16'h8000 : 16'h00FF;
        end
        run_curve("R5", 9, 80, 1'b0);

        fill_random();
        run_curve("R11", 6, 70, 1'b1);
        run_curve("R3", 300, 90, 1'b0);
        run_curve("R8", 600, 100, 1'b0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule